// File: doc/BRIEF.md
# Spindle Motor Speed Regulator

This block regulates the rotation speed of a disc spindle motor. On each strobed sample it compares a measured motor frequency against a programmed frequency target and runs a proportional-plus-integral correction. A third term, taken from the fill level of the downstream data buffer relative to a programmed fill target, fine-tunes the speed so that the incoming data rate follows a fixed output rate. The correction is saturated and then drives one of two motor outputs. Positive corrections go to the forward output and negative corrections go to the reverse output. Each output is modulated as either pulse-width or pulse-density.

Configuration arrives on plain ports, with the bus decoding done outside the block. These ports choose one of four operating modes: shutdown, open-loop spin-up, open-loop braking and closed-loop regulation. They also choose the output format, the gains, the two targets and which of two frequency inputs feeds the loop. The integrator value can be read back as two bytes. A level overflow flag reports saturation in the gain stage or the modulator range, and it can open both motor switches automatically.

Top module: `spindle_pi_ctrl`

## Requirements
- R1: With cfgMode = 2'b00 (shutdown), from the next clock both motor outputs are low, the integrator reads 0 and ovfFlag is 0.
- R2: With cfgMode = 2'b01 (spin-up), motorFwd is high for START_DUTY (default 200) of every 256 clocks and motorRev stays low. With cfgMode = 2'b10 (braking), motorRev is high for STOP_DUTY (default 64) of every 256 clocks and motorFwd stays low. In both modes a sample strobe leaves the integrator unchanged.
- R3: With cfgPdm = 0 the active output is a 256-clock PWM with one contiguous high run per period. With cfgPdm = 1 it is a first-order sigma-delta stream with the same number of ones per 256 clocks, and there are no two adjacent ones when the duty is 128 or less.
- R4: With cfgMode = 2'b11 (closed loop), each clock with sampleValid = 1 forms err = cfgFreqSet - (cfgFreqSel ? freqB : freqA). That clock updates the integrator to clamp(I + Ki*err, -32767, +32767). After that edge, integLo reads integrator bits 7:0 and integHi reads bits 15:8, in two's complement.
- R5: The same sample sets drive = clamp(Kp*err + floor(Inew/16) + Kf*(fillLevel - fillTarget), -2047, +2047). A positive drive puts a duty of |drive| >> 3 per 256 clocks on motorFwd. A negative drive puts it on motorRev. The other output stays low.
- R6: The fill target used in R5 is cfgFillSet clamped into 118..128.
- R7: ovfFlag is 1 after a closed-loop sample in which the integrator or the drive was clamped. It returns to 0 after the next sample that clamps neither. It is 0 in every mode other than closed loop.
- R8: When cfgAutoSw = 1, both sw1Open and sw2Open follow ovfFlag. When cfgAutoSw = 0, both are low.
- R9: motorFwd and motorRev are never high together.
- R10: After reset, all outputs are low and the integrator reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| cfgMode | input | 2 | 00 shutdown, 01 spin-up, 10 braking, 11 closed loop |
| cfgPdm | input | 1 | 1 selects pulse-density output, 0 selects PWM |
| cfgAutoSw | input | 1 | lets overflow open the motor switches |
| cfgFreqSel | input | 1 | 1 selects freqB as the loop input, 0 selects freqA |
| cfgKp | input | GAIN_W | proportional gain |
| cfgKi | input | GAIN_W | integral gain |
| cfgKf | input | GAIN_W | fill-level gain |
| cfgFreqSet | input | FREQ_W | frequency target |
| cfgFillSet | input | FILL_W | buffer fill target |
| freqA | input | FREQ_W | measured frequency, source A |
| freqB | input | FREQ_W | measured frequency, source B |
| fillLevel | input | FILL_W | current buffer fill level |
| sampleValid | input | 1 | strobe for one loop update |
| motorFwd | output | 1 | forward motor drive |
| motorRev | output | 1 | reverse motor drive |
| integLo | output | 8 | integrator low byte |
| integHi | output | 8 | integrator high byte |
| ovfFlag | output | 1 | saturation status |
| sw1Open | output | 1 | open command, switch 1 |
| sw2Open | output | 1 | open command, switch 2 |

## Verification
The bench sweeps measured frequency across its full range for several gain combinations and tracks an arithmetic model of the integrator, drive and flag. This exposes integrators that wrap instead of clamping, and a floor shift that rounds toward zero on negative values. It drives the integrator into saturation and then backs it off, which catches a flag that latches instead of following the level and switch outputs that ignore the enable. It measures ones and rising edges over whole 256-clock windows, which separates PWM from PDM and exposes a swapped direction or the wrong fixed duty. It probes fill targets outside 118..128 to catch a missing clamp, and it probes the frequency-source select to catch a swapped select.

// File: rtl/spindle_pkg.sv
package spindle_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_START = 2'b01,
    MODE_STOP  = 2'b10,
    MODE_RUN   = 2'b11
  } mode_e;

  // strobes from control to datapath and modulator
  typedef struct packed {
    logic step;      // closed-loop update this clock
    logic clear;     // shutdown: clear state, outputs low
    logic fixedFwd;  // open-loop spin-up
    logic fixedRev;  // open-loop braking
    logic pdm;       // output format
  } strobe_t;

  localparam int INT_W   = 16;
  localparam int DUTY_W  = 8;
  localparam int FILL_LO = 118;
  localparam int FILL_HI = 128;

endpackage

// File: rtl/spindle_ctl.sv
module spindle_ctl
  import spindle_pkg::*;
(
  input  logic       [1:0] cfgMode,
  input  logic             cfgPdm,
  input  logic             cfgAutoSw,
  input  logic             sampleValid,
  input  logic             ovfFlag,
  output strobe_t          strobe,
  output logic             sw1Open,
  output logic             sw2Open
);

  mode_e mode;
  logic  openReq;

  assign mode = mode_e'(cfgMode);

  always_comb begin
    strobe          = '0;
    strobe.pdm      = cfgPdm;
    unique case (mode)
      MODE_OFF:   strobe.clear    = 1'b1;
      MODE_START: strobe.fixedFwd = 1'b1;
      MODE_STOP:  strobe.fixedRev = 1'b1;
      MODE_RUN:   strobe.step     = sampleValid;
      default:    strobe.clear    = 1'b1;
    endcase
  end

  assign openReq = cfgAutoSw & ovfFlag;
  assign sw1Open = openReq;
  assign sw2Open = openReq;

endmodule

// File: rtl/spindle_dp.sv
module spindle_dp
  import spindle_pkg::*;
#(
  parameter int FREQ_W = 8,
  parameter int FILL_W = 8,
  parameter int GAIN_W = 4,
  parameter int OUT_W  = 12,
  parameter int ISHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic                    cfgFreqSel,
  input  logic [GAIN_W-1:0]       cfgKp,
  input  logic [GAIN_W-1:0]       cfgKi,
  input  logic [GAIN_W-1:0]       cfgKf,
  input  logic [FREQ_W-1:0]       cfgFreqSet,
  input  logic [FILL_W-1:0]       cfgFillSet,
  input  logic [FREQ_W-1:0]       freqA,
  input  logic [FREQ_W-1:0]       freqB,
  input  logic [FILL_W-1:0]       fillLevel,
  output logic signed [INT_W-1:0] integ,
  output logic signed [OUT_W-1:0] drive,
  output logic                    ovfFlag
);

  localparam int CW    = 32;
  localparam int I_LIM = (1 << (INT_W - 1)) - 1;
  localparam int O_LIM = (1 << (OUT_W - 1)) - 1;

  logic [FREQ_W-1:0]   measSel;
  logic signed [CW-1:0] err, posErr, fillTgt, fillReq;
  logic signed [CW-1:0] iSum, iNext, uSum, uNext;
  logic                 iSat, uSat;

  assign measSel = cfgFreqSel ? freqB : freqA;

  always_comb begin
    err     = $signed(CW'(cfgFreqSet)) - $signed(CW'(measSel));
    fillReq = $signed(CW'(cfgFillSet));
    if (fillReq < FILL_LO)      fillTgt = FILL_LO;
    else if (fillReq > FILL_HI) fillTgt = FILL_HI;
    else                        fillTgt = fillReq;
    posErr  = $signed(CW'(fillLevel)) - fillTgt;

    iSum = CW'(integ) + $signed(CW'(cfgKi)) * err;
    iSat = (iSum > I_LIM) || (iSum < -I_LIM);
    if (iSum > I_LIM)       iNext = I_LIM;
    else if (iSum < -I_LIM) iNext = -I_LIM;
    else                    iNext = iSum;

    uSum = $signed(CW'(cfgKp)) * err + (iNext >>> ISHIFT)
         + $signed(CW'(cfgKf)) * posErr;
    uSat = (uSum > O_LIM) || (uSum < -O_LIM);
    if (uSum > O_LIM)       uNext = O_LIM;
    else if (uSum < -O_LIM) uNext = -O_LIM;
    else                    uNext = uSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integ   <= '0;
      drive   <= '0;
      ovfFlag <= 1'b0;
    end else if (strobe.clear) begin
      integ   <= '0;
      drive   <= '0;
      ovfFlag <= 1'b0;
    end else if (strobe.fixedFwd || strobe.fixedRev) begin
      ovfFlag <= 1'b0;
    end else if (strobe.step) begin
      integ   <= iNext[INT_W-1:0];
      drive   <= uNext[OUT_W-1:0];
      ovfFlag <= iSat | uSat;
    end
  end

endmodule

// File: rtl/spindle_mod.sv
module spindle_mod
  import spindle_pkg::*;
#(
  parameter int OUT_W      = 12,
  parameter int START_DUTY = 200,
  parameter int STOP_DUTY  = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic signed [OUT_W-1:0] drive,
  output logic                    motorFwd,
  output logic                    motorRev
);

  logic [OUT_W-1:0]  mag;
  logic [DUTY_W-1:0] loopDuty, dutySel, phase, acc;
  logic [DUTY_W:0]   accSum;
  logic              onFwd, onRev, pwmBit, modBit;

  assign mag      = drive[OUT_W-1] ? OUT_W'(-drive) : OUT_W'(drive);
  assign loopDuty = mag[OUT_W-2 -: DUTY_W];

  always_comb begin
    dutySel = '0;
    onFwd   = 1'b0;
    onRev   = 1'b0;
    if (strobe.fixedFwd) begin
      dutySel = DUTY_W'(START_DUTY);
      onFwd   = 1'b1;
    end else if (strobe.fixedRev) begin
      dutySel = DUTY_W'(STOP_DUTY);
      onRev   = 1'b1;
    end else if (!strobe.clear) begin
      dutySel = loopDuty;
      onFwd   = ~drive[OUT_W-1];
      onRev   = drive[OUT_W-1];
    end
  end

  assign accSum = {1'b0, acc} + {1'b0, dutySel};
  assign pwmBit = phase < dutySel;
  assign modBit = strobe.pdm ? accSum[DUTY_W] : pwmBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      acc      <= '0;
      motorFwd <= 1'b0;
      motorRev <= 1'b0;
    end else begin
      phase    <= phase + 1'b1;
      acc      <= accSum[DUTY_W-1:0];
      motorFwd <= onFwd & modBit;
      motorRev <= onRev & modBit;
    end
  end

endmodule

// File: rtl/spindle_pi_ctrl.sv
module spindle_pi_ctrl
  import spindle_pkg::*;
#(
  parameter int FREQ_W     = 8,
  parameter int FILL_W     = 8,
  parameter int GAIN_W     = 4,
  parameter int OUT_W      = 12,
  parameter int ISHIFT     = 4,
  parameter int START_DUTY = 200,
  parameter int STOP_DUTY  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic              cfgPdm,
  input  logic              cfgAutoSw,
  input  logic              cfgFreqSel,
  input  logic [GAIN_W-1:0] cfgKp,
  input  logic [GAIN_W-1:0] cfgKi,
  input  logic [GAIN_W-1:0] cfgKf,
  input  logic [FREQ_W-1:0] cfgFreqSet,
  input  logic [FILL_W-1:0] cfgFillSet,
  input  logic [FREQ_W-1:0] freqA,
  input  logic [FREQ_W-1:0] freqB,
  input  logic [FILL_W-1:0] fillLevel,
  input  logic              sampleValid,
  output logic              motorFwd,
  output logic              motorRev,
  output logic [7:0]        integLo,
  output logic [7:0]        integHi,
  output logic              ovfFlag,
  output logic              sw1Open,
  output logic              sw2Open
);

  strobe_t                 strobe;
  logic signed [INT_W-1:0] integ;
  logic signed [OUT_W-1:0] drive;

  spindle_ctl u_ctl (
    .cfgMode(cfgMode), .cfgPdm(cfgPdm), .cfgAutoSw(cfgAutoSw),
    .sampleValid(sampleValid), .ovfFlag(ovfFlag), .strobe(strobe),
    .sw1Open(sw1Open), .sw2Open(sw2Open)
  );

  spindle_dp #(
    .FREQ_W(FREQ_W), .FILL_W(FILL_W), .GAIN_W(GAIN_W),
    .OUT_W(OUT_W), .ISHIFT(ISHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgFreqSel(cfgFreqSel),
    .cfgKp(cfgKp), .cfgKi(cfgKi), .cfgKf(cfgKf),
    .cfgFreqSet(cfgFreqSet), .cfgFillSet(cfgFillSet),
    .freqA(freqA), .freqB(freqB), .fillLevel(fillLevel),
    .integ(integ), .drive(drive), .ovfFlag(ovfFlag)
  );

  spindle_mod #(
    .OUT_W(OUT_W), .START_DUTY(START_DUTY), .STOP_DUTY(STOP_DUTY)
  ) u_mod (
    .clk(clk), .rstN(rstN), .strobe(strobe), .drive(drive),
    .motorFwd(motorFwd), .motorRev(motorRev)
  );

  assign integLo = integ[7:0];
  assign integHi = integ[15:8];

endmodule

// File: rtl/spindle_chk.sv
module spindle_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] cfgMode,
  input logic       cfgAutoSw,
  input logic       motorFwd,
  input logic       motorRev,
  input logic [7:0] integLo,
  input logic [7:0] integHi,
  input logic       ovfFlag,
  input logic       sw1Open,
  input logic       sw2Open
);

  // R1: shutdown clears state and silences both outputs
  a_r1_shutdown_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode == 2'b00 |=> (!motorFwd && !motorRev && !ovfFlag && {integHi, integLo} == 16'h0000));

  // R2: open-loop modes leave the integrator untouched
  a_r2_integ_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b01 || cfgMode == 2'b10) |=> $stable({integHi, integLo}));

  // R2: spin-up never drives reverse, braking never drives forward
  a_r2_fixed_dir: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b01 |=> !motorRev) and (cfgMode == 2'b10 |=> !motorFwd));

  // R7: flag stays low outside closed loop
  a_r7_ovf_idle: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode != 2'b11 |=> !ovfFlag);

  // R8: switches stay closed without the enable, and move together
  a_r8_switch_gate: assert property (@(posedge clk) disable iff (!rstN)
    !cfgAutoSw |-> (!sw1Open && !sw2Open));
  a_r8_switch_pair: assert property (@(posedge clk) disable iff (!rstN)
    sw1Open == sw2Open);
  a_r8_switch_needs_ovf: assert property (@(posedge clk) disable iff (!rstN)
    sw1Open |-> ovfFlag);

  // R9: the two motor outputs never overlap
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(motorFwd && motorRev));

endmodule

bind spindle_pi_ctrl spindle_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgAutoSw(cfgAutoSw),
  .motorFwd(motorFwd), .motorRev(motorRev), .integLo(integLo),
  .integHi(integHi), .ovfFlag(ovfFlag), .sw1Open(sw1Open), .sw2Open(sw2Open)
);

// File: tb/spindle_pi_ctrl_test.sv
module spindle_pi_ctrl_test;

  localparam int START_DUTY = 200;
  localparam int STOP_DUTY  = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic       cfgPdm = 1'b0, cfgAutoSw = 1'b0, cfgFreqSel = 1'b0;
  logic [3:0] cfgKp = '0, cfgKi = '0, cfgKf = '0;
  logic [7:0] cfgFreqSet = '0, cfgFillSet = 8'd120;
  logic [7:0] freqA = '0, freqB = '0, fillLevel = 8'd120;
  logic       sampleValid = 1'b0;
  logic       motorFwd, motorRev, ovfFlag, sw1Open, sw2Open;
  logic [7:0] integLo, integHi;

  int nChecks = 0, nFails = 0;
  int mI = 0, mDrive = 0;
  bit mOvf = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spindle_pi_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgPdm(cfgPdm),
    .cfgAutoSw(cfgAutoSw), .cfgFreqSel(cfgFreqSel), .cfgKp(cfgKp),
    .cfgKi(cfgKi), .cfgKf(cfgKf), .cfgFreqSet(cfgFreqSet),
    .cfgFillSet(cfgFillSet), .freqA(freqA), .freqB(freqB),
    .fillLevel(fillLevel), .sampleValid(sampleValid),
    .motorFwd(motorFwd), .motorRev(motorRev), .integLo(integLo),
    .integHi(integHi), .ovfFlag(ovfFlag), .sw1Open(sw1Open), .sw2Open(sw2Open)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampTo(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int readInteg();
    return int'($signed({integHi, integLo}));
  endfunction

  // arithmetic model of one closed-loop sample
  task automatic modelStep();
    int err, iSum, u, tgt;
    bit s1, s2;
    err  = int'(cfgFreqSet) - (cfgFreqSel ? int'(freqB) : int'(freqA));
    iSum = mI + int'(cfgKi) * err;
    s1   = (iSum > 32767) || (iSum < -32767);
    mI   = clampTo(iSum, 32767);
    tgt  = int'(cfgFillSet);
    if (tgt < 118) tgt = 118;
    if (tgt > 128) tgt = 128;
    u    = int'(cfgKp) * err + (mI >>> 4) + int'(cfgKf) * (int'(fillLevel) - tgt);
    s2   = (u > 2047) || (u < -2047);
    mDrive = clampTo(u, 2047);
    mOvf = s1 || s2;
  endtask

  task automatic sample();
    @(negedge clk);
    sampleValid = 1'b1;
    if (cfgMode == 2'b11) modelStep();
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic shutdown();
    @(negedge clk);
    cfgMode = 2'b00;
    repeat (2) @(negedge clk);
    mI = 0; mDrive = 0; mOvf = 0;
    check(readInteg() == 0 && !ovfFlag && !motorFwd && !motorRev, "R1 shutdown state",
          readInteg(), 0);
  endtask

  task automatic measure(output int fOnes, output int rOnes, output int fRise, output int rRise);
    logic pf, pr;
    repeat (4) @(negedge clk);
    fOnes = 0; rOnes = 0; fRise = 0; rRise = 0;
    pf = motorFwd; pr = motorRev;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      fOnes += int'(motorFwd);
      rOnes += int'(motorRev);
      if (motorFwd && !pf) fRise++;
      if (motorRev && !pr) rRise++;
      pf = motorFwd; pr = motorRev;
    end
  endtask

  task automatic checkDrive(input string tag);
    int fo, ro, fr, rr, ef, er;
    ef = (mDrive > 0) ? (mDrive >> 3) : 0;
    er = (mDrive < 0) ? ((-mDrive) >> 3) : 0;
    measure(fo, ro, fr, rr);
    check(fo == ef, {tag, " forward duty"}, fo, ef);
    check(ro == er, {tag, " reverse duty"}, ro, er);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int kps[3] = '{0, 3, 15};
    int kis[2] = '{1, 7};
    int kfs[2] = '{0, 5};
    int fo, ro, fr, rr, combo;

    repeat (3) @(negedge clk);
    // R10: reset state
    check(!motorFwd && !motorRev && !ovfFlag && !sw1Open && !sw2Open, "R10 outputs low", 0, 0);
    check(readInteg() == 0, "R10 integrator", readInteg(), 0);
    rstN = 1'b1;

    // R4 R5 R7 R8 sweep over measured frequency for several gains
    combo = 0;
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 2; b++) begin
        for (int c = 0; c < 2; c++) begin
          shutdown();
          cfgKp = 4'(kps[a]); cfgKi = 4'(kis[b]); cfgKf = 4'(kfs[c]);
          cfgFreqSet = 8'd130; cfgFillSet = 8'd122; fillLevel = 8'd119;
          cfgAutoSw = combo[0]; cfgPdm = combo[1];
          cfgFreqSel = combo[2];
          cfgMode = 2'b11;
          for (int m = 0; m < 256; m += 15) begin
            freqA = cfgFreqSel ? 8'(255 - m) : 8'(m);
            freqB = cfgFreqSel ? 8'(m) : 8'(255 - m);
            sample();
            check(readInteg() == mI, "R4 integrator readback", readInteg(), mI);
            check(ovfFlag == mOvf, "R7 overflow level", int'(ovfFlag), int'(mOvf));
            check(sw1Open == (cfgAutoSw && mOvf) && sw2Open == sw1Open, "R8 switches",
                  int'(sw1Open), int'(cfgAutoSw && mOvf));
          end
          freqA = 8'd120; freqB = 8'd120;
          sample();
          checkDrive("R5 loop drive");
          combo++;
        end
      end
    end

    // R6: fill target clamp, low and high side
    shutdown();
    cfgKp = 4'd0; cfgKi = 4'd0; cfgKf = 4'd8; cfgFreqSel = 1'b0; cfgPdm = 1'b0;
    cfgFreqSet = 8'd50; freqA = 8'd50; cfgMode = 2'b11;
    cfgFillSet = 8'd100; fillLevel = 8'd200;
    sample();
    check(mDrive == 656, "R6 model low clamp", mDrive, 656);
    checkDrive("R6 low target clamp");
    cfgFillSet = 8'd140; fillLevel = 8'd100;
    sample();
    checkDrive("R6 high target clamp");

    // R4: frequency source select picks freqB
    shutdown();
    cfgKp = 4'd2; cfgKi = 4'd3; cfgKf = 4'd0; cfgFreqSel = 1'b1;
    cfgFreqSet = 8'd100; freqA = 8'd0; freqB = 8'd90; cfgMode = 2'b11;
    sample();
    check(readInteg() == 30, "R4 source select", readInteg(), 30);

    // R7 R8: saturate integrator, then back off
    shutdown();
    cfgKp = 4'd0; cfgKi = 4'd15; cfgKf = 4'd0; cfgFreqSel = 1'b0; cfgAutoSw = 1'b1;
    cfgFillSet = 8'd120; fillLevel = 8'd120;
    cfgFreqSet = 8'd255; freqA = 8'd0; cfgMode = 2'b11;
    for (int s = 0; s < 9; s++) sample();
    check(readInteg() == 32767, "R4 integrator clamps high", readInteg(), 32767);
    check(ovfFlag == 1'b1, "R7 overflow set", int'(ovfFlag), 1);
    check(sw1Open && sw2Open, "R8 switches open", int'(sw1Open), 1);
    cfgAutoSw = 1'b0;
    @(negedge clk);
    check(!sw1Open && !sw2Open, "R8 switches gated", int'(sw1Open), 0);
    cfgFreqSet = 8'd0; freqA = 8'd100;
    sample();
    check(ovfFlag == 1'b0, "R7 overflow clears", int'(ovfFlag), 0);
    check(readInteg() == mI, "R4 integrator after back-off", readInteg(), mI);

    // R2 R3 R7: spin-up in PWM
    cfgPdm = 1'b0; cfgMode = 2'b01;
    mI = readInteg();
    sample(); sample();
    check(readInteg() == mI, "R2 integrator held in spin-up", readInteg(), mI);
    check(!ovfFlag, "R7 flag low in spin-up", int'(ovfFlag), 0);
    measure(fo, ro, fr, rr);
    check(fo == START_DUTY, "R2 spin-up duty", fo, START_DUTY);
    check(ro == 0, "R2 spin-up reverse low", ro, 0);
    check(fr == 1, "R3 PWM single run", fr, 1);

    // R2 R3: braking in PDM
    cfgPdm = 1'b1; cfgMode = 2'b10;
    sample();
    check(readInteg() == mI, "R2 integrator held in braking", readInteg(), mI);
    measure(fo, ro, fr, rr);
    check(ro == STOP_DUTY, "R2 braking duty", ro, STOP_DUTY);
    check(fo == 0, "R2 braking forward low", fo, 0);
    check(rr == STOP_DUTY, "R3 PDM isolated ones", rr, STOP_DUTY);

    // R1: shutdown from running state
    shutdown();
    measure(fo, ro, fr, rr);
    check(fo == 0 && ro == 0, "R1 outputs silent", fo + ro, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule